// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two 32-bit operands and either writes the product straight into a 64-bit accumulator or adds it to the value already held there. The accumulator is exposed as a high word and a low word. Four operations share one datapath: a signed full-width product, an unsigned full-width product, a signed 32x32 accumulate, and a signed 16x16 accumulate that uses only the low halves of the operands. When the saturation input is set, the two accumulate forms clamp their result, and each form uses its own rule.

Operands enter through a valid/ready handshake. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while `clr` is asserted, so clearing is the only source of back-pressure. The unit is a two-stage pipeline. The first stage registers the product. The second stage folds that product into the accumulator and pulses `done`. One operation can be accepted on every cycle. An accumulate always sees the result of the operation accepted one cycle before it, so no stall is needed.

Top module: `mac_unit`

## Requirements
- R1: After reset, `acc_hi`, `acc_lo` and `done` are all zero.
- R2: op_sel=0 (signed multiply) loads the accumulator with the signed 64-bit product of `opa` and `opb`, with bits 63:32 in `acc_hi` and bits 31:0 in `acc_lo`. The previous contents are discarded.
- R3: op_sel=1 (unsigned multiply) loads the accumulator with the unsigned 64-bit product of `opa` and `opb`, also discarding the previous contents.
- R4: op_sel=2 (wide accumulate) with `sat_en`=0 adds the signed 32x32 product to the 64-bit accumulator and keeps the wrapped 64-bit sum.
- R5: op_sel=2 with `sat_en`=1 and a negative 64-bit sum forces bits 31:16 of `acc_hi` to ones. The other bits keep the sum.
- R6: op_sel=2 with `sat_en`=1 and a non-negative sum clears bits 31:15 of `acc_hi`. The other bits keep the sum.
- R7: op_sel=3 (narrow accumulate) sign-extends bits 15:0 of each operand, ignores bits 31:16, and adds the product to the accumulator. With `sat_en`=0 it keeps the wrapped 64-bit sum.
- R8: op_sel=3 with `sat_en`=1 and a sum below -2^31 sets `acc_hi`=1 and `acc_lo`=0x80000000.
- R9: op_sel=3 with `sat_en`=1 and a sum above 0x7FFFFFFF sets `acc_hi`=1 and `acc_lo`=0x7FFFFFFF.
- R10: op_sel=3 with `sat_en`=1 and a sum inside the 32-bit signed range stores the sum unchanged.
- R11: An operation accepted at rising edge E writes the accumulator at edge E+1. `done` is high for exactly the one cycle after that write, and it is never high without an accepted operation.
- R12: While `clr` is high, `in_ready` is low. At the next edge both accumulator halves become zero. An operation whose write would fall on that edge is dropped and does not raise `done`.
- R13: Operations may be accepted on consecutive cycles. Each accumulate adds to the result of the operation accepted just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and operation are presented |
| in_ready | output | 1 | Unit can accept an operation (low while clearing) |
| op_sel | input | 2 | 0 signed mul, 1 unsigned mul, 2 wide accumulate, 3 narrow accumulate |
| sat_en | input | 1 | Saturate the accumulate forms |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| clr | input | 1 | Zero the accumulator |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| done | output | 1 | One-cycle pulse when the accumulator takes a result |

## Verification
Every result is due after the second rising edge counting the accepting edge, and the effect of a clear is due after the first edge. `in_ready` follows `clr` in the same cycle. The bench keeps a cycle-accurate model that is stepped on each rising edge from the inputs sampled there. It compares the accumulator, `done` and `in_ready` a quarter period after every edge. Stimulus is driven on falling edges, so inputs and outputs never change at the same instant.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_SMUL = 2'd0,
    OP_UMUL = 2'd1,
    OP_MACL = 2'd2,
    OP_MACW = 2'd3
  } mac_op_e;
endpackage

// File: rtl/mac_mul.sv
// Stage 1: operand extension and product register.
module mac_mul
  import mac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  mac_op_e         op,
  input  logic            sat,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic            p_valid,
  output mac_op_e         p_op,
  output logic            p_sat,
  output logic [2*DW-1:0] p_prod
);
  localparam int AW = 2 * DW;
  localparam int HW = DW / 2;

  logic [AW-1:0] xa, xb, prod_d;

  always_comb begin
    unique case (op)
      OP_UMUL: begin
        xa = {{DW{1'b0}}, a};
        xb = {{DW{1'b0}}, b};
      end
      OP_MACW: begin
        xa = {{(AW-HW){a[HW-1]}}, a[HW-1:0]};
        xb = {{(AW-HW){b[HW-1]}}, b[HW-1:0]};
      end
      default: begin
        xa = {{DW{a[DW-1]}}, a};
        xb = {{DW{b[DW-1]}}, b};
      end
    endcase
    prod_d = xa * xb;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_valid <= 1'b0;
      p_op    <= OP_SMUL;
      p_sat   <= 1'b0;
      p_prod  <= '0;
    end else begin
      p_valid <= take;
      if (take) begin
        p_op   <= op;
        p_sat  <= sat;
        p_prod <= prod_d;
      end
    end
  end
endmodule

// File: rtl/mac_acc.sv
// Stage 2: accumulate, saturate, write.
module mac_acc
  import mac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            p_valid,
  input  mac_op_e         p_op,
  input  logic            p_sat,
  input  logic [2*DW-1:0] p_prod,
  output logic [2*DW-1:0] acc,
  output logic            done
);
  localparam int AW = 2 * DW;
  localparam int HW = DW / 2;
  localparam logic [AW-1:0] NARROW_MIN = {{(DW+1){1'b1}}, {(DW-1){1'b0}}};
  localparam logic [AW-1:0] NARROW_MAX = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] FLAG_HI    = DW'(1);

  logic [AW-1:0] sum, nxt;

  always_comb begin
    sum = acc + p_prod;
    nxt = sum;
    unique case (p_op)
      OP_SMUL, OP_UMUL: nxt = p_prod;
      OP_MACL: begin
        if (p_sat) begin
          if (sum[AW-1]) nxt[AW-1:AW-HW] = '1;
          else           nxt[AW-1:DW+HW-1] = '0;
        end
      end
      default: begin
        if (p_sat) begin
          if ($signed(sum) < $signed(NARROW_MIN))
            nxt = {FLAG_HI, 1'b1, {(DW-1){1'b0}}};
          else if ($signed(sum) > $signed(NARROW_MAX))
            nxt = {FLAG_HI, 1'b0, {(DW-1){1'b1}}};
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      done <= 1'b0;
    end else if (clr) begin
      acc  <= '0;
      done <= 1'b0;
    end else begin
      done <= p_valid;
      if (p_valid) acc <= nxt;
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    op_sel,
  input  logic          sat_en,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          clr,
  output logic [DW-1:0] acc_hi,
  output logic [DW-1:0] acc_lo,
  output logic          done
);
  localparam int AW = 2 * DW;

  logic          take, p_valid, p_sat;
  mac_op_e       p_op;
  logic [AW-1:0] p_prod, acc;

  assign in_ready = ~clr;
  assign take     = in_valid & in_ready;

  mac_mul #(.DW(DW)) u_mul (
    .clk(clk), .rst_n(rst_n), .take(take), .op(mac_op_e'(op_sel)),
    .sat(sat_en), .a(opa), .b(opb),
    .p_valid(p_valid), .p_op(p_op), .p_sat(p_sat), .p_prod(p_prod)
  );

  mac_acc #(.DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .p_valid(p_valid), .p_op(p_op),
    .p_sat(p_sat), .p_prod(p_prod), .acc(acc), .done(done)
  );

  assign acc_hi = acc[AW-1:DW];
  assign acc_lo = acc[DW-1:0];
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    op_sel,
  input logic          sat_en,
  input logic [DW-1:0] opa,
  input logic [DW-1:0] opb,
  input logic          clr,
  input logic [DW-1:0] acc_hi,
  input logic [DW-1:0] acc_lo,
  input logic          done
);
  localparam int AW = 2 * DW;
  localparam int HW = DW / 2;

  logic          acc_t;
  logic [AW-1:0] sprod;
  assign acc_t = in_valid & in_ready;
  assign sprod = {{DW{opa[DW-1]}}, opa} * {{DW{opb[DW-1]}}, opb};

  // R12
  clr_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !in_ready);

  // R12
  clr_zeroes_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_hi == '0 && acc_lo == '0 && !done));

  // R11
  accept_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_t ##1 !clr |=> done);

  // R11
  done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(acc_t, 2));

  // R2
  signed_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(acc_t && op_sel == 2'd0, 2)) |-> {acc_hi, acc_lo} == $past(sprod, 2));

  // R5 R6
  wide_sat_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(acc_t && op_sel == 2'd2 && sat_en, 2)) |->
      (acc_hi[DW-1:HW] == '1 || acc_hi[DW-1:HW-1] == '0));
endmodule

bind mac_unit mac_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op_sel(op_sel), .sat_en(sat_en), .opa(opa), .opb(opb), .clr(clr),
  .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
);

// File: tb/mac_unit_tb.sv
module mac_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  op_sel = 2'd0;
  logic        sat_en = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic        clr = 1'b0;
  logic [31:0] acc_hi, acc_lo;
  logic        done;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  mac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sel(op_sel), .sat_en(sat_en), .opa(opa), .opb(opb), .clr(clr),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected next accumulator value from the requirements.
  function automatic logic [63:0] expect_next(logic [1:0] op, bit sat,
      logic [31:0] a, logic [31:0] b, logic [63:0] acc, output string tag);
    longint s, p;
    logic [31:0] h;
    case (op)
      2'd0: begin tag = "R2"; return longint'($signed(a)) * longint'($signed(b)); end
      2'd1: begin tag = "R3"; return {32'b0, a} * {32'b0, b}; end
      2'd2: begin
        s = longint'(acc) + longint'($signed(a)) * longint'($signed(b));
        if (!sat) begin tag = "R4"; return s; end
        h = s[63:32];
        if (s < 0) begin h = h | 32'hFFFF0000; tag = "R5"; end
        else       begin h = h & 32'h00007FFF; tag = "R6"; end
        return {h, s[31:0]};
      end
      default: begin
        p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        s = longint'(acc) + p;
        if (!sat) begin tag = "R7"; return s; end
        if (s < -64'sd2147483648) begin tag = "R8"; return {32'd1, 32'h80000000}; end
        if (s > 64'sd2147483647)  begin tag = "R9"; return {32'd1, 32'h7FFFFFFF}; end
        tag = "R10";
        return s;
      end
    endcase
  endfunction

  logic [63:0] m_acc = '0;
  bit          m_done = 1'b0;
  bit          p_v = 1'b0, p_sat = 1'b0;
  logic [1:0]  p_op = '0;
  logic [31:0] p_a = '0, p_b = '0;
  string       m_tag = "R1";

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = '0; m_done = 0; p_v = 0; m_tag = "R1";
    end else begin
      m_done = 0;
      if (clr) begin
        m_acc = '0; m_tag = "R12";
      end else if (p_v) begin
        m_acc = expect_next(p_op, p_sat, p_a, p_b, m_acc, m_tag);
        m_done = 1;
      end else m_tag = "R11";
      p_v = in_valid && !clr;
      p_op = op_sel; p_sat = sat_en; p_a = opa; p_b = opb;
    end
    #(CLK_PERIOD/4);
    if (rst_n && !finished) begin
      check({acc_hi, acc_lo} === m_acc, m_tag, "acc", {acc_hi, acc_lo}, m_acc);
      check(done === m_done, m_done ? m_tag : "R11", "done", 64'(done), 64'(m_done));
      check(in_ready === !clr, "R12", "in_ready", 64'(in_ready), 64'(!clr));
    end
  end

  task automatic issue(logic [1:0] op, bit sat, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    in_valid = 1; clr = 0; op_sel = op; sat_en = sat; opa = a; opb = b;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; clr = 0;
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    in_valid = 0; clr = 1;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h0;
      1: return 32'hFFFFFFFF;
      2: return 32'h80000000;
      3: return 32'h7FFFFFFF;
      4: return {16'($urandom), 16'h8000};
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check({acc_hi, acc_lo} === 64'h0 && done === 1'b0, "R1", "reset",
          {acc_hi, acc_lo}, 64'h0);
    // R2 R3: products overwrite accumulator
    issue(2'd0, 0, 32'hFFFFFFFF, 32'h00000002);
    issue(2'd1, 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    idle(3);
    // R5: negative wide sum with saturation
    do_clear();
    issue(2'd2, 1, 32'hFFFFFFFF, 32'h00000001);
    // R6: large positive wide sum with saturation
    do_clear();
    issue(2'd2, 1, 32'h7FFFFFFF, 32'h7FFFFFFF);
    // R4: wrapped wide sum
    issue(2'd2, 0, 32'h80000000, 32'h80000000);
    idle(3);
    // R9 R13: narrow positive overflow, back to back, upper bits ignored (R7)
    do_clear();
    issue(2'd3, 1, 32'hABCD8000, 32'h12348000);
    issue(2'd3, 1, 32'h00008000, 32'hFFFF8000);
    issue(2'd3, 1, 32'h00008000, 32'h00008000);
    idle(3);
    // R8 R10: narrow negative overflow
    do_clear();
    issue(2'd3, 1, 32'h00008000, 32'h00007FFF);
    issue(2'd3, 1, 32'h00008000, 32'h00007FFF);
    issue(2'd3, 1, 32'h00008000, 32'h00007FFF);
    idle(3);
    // R12: clear lands on an in-flight write
    issue(2'd1, 0, 32'h12345678, 32'h9ABCDEF0);
    do_clear();
    idle(3);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      clr      = ($urandom_range(0, 39) == 0);
      in_valid = ($urandom_range(0, 3) != 0);
      op_sel   = 2'($urandom_range(0, 3));
      sat_en   = $urandom_range(0, 1);
      opa      = pick();
      opb      = pick();
    end
    idle(4);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule